// File: doc/BRIEF.md
# Pulse-triggered master-slave JK flip-flop

This block is a behavioural model of a pulse-triggered master-slave JK storage element. It lives inside a fast system-clock domain. The element's own clock, called the device clock, arrives as an ordinary input. A two-stage synchronizer samples that clock together with the data and control lines, and the block detects its rising and falling edges from the sampled values. The J function is the AND of three input lines, and the K function is the AND of three further lines.

On a rising device-clock edge the gated J/K result goes into the master stage. On the following falling edge the master is copied into the slave, and only then do the complementary outputs move. Two active-low controls override the outputs combinationally: preset and clear. Both of them low drives both outputs high.

Two sticky flags report misuse of the element:
- The hold flag is set when a gated J or K value changes while the device clock is high.
- The width flag is set when any of four phases is shorter than a configurable number of system-clock cycles. The four phases are device clock high, device clock low, preset low and clear low.

A clear-flags pulse resets both flags.

Top module: `jk_ms_ff`

## Requirements
- R1: The gated J is the AND of the three lines of j_i, and the gated K is the AND of the three lines of k_i. A partial set of high lines counts as 0.
- R2: The master loads the gated J/K result on the rising device-clock edge. Changes of j_i/k_i while the device clock is high have no effect on the value that is later transferred.
- R3: With preset and clear inactive, q_o/qn_o change only after a falling device-clock edge, never during the high phase.
- R4: After each complete high pulse, the gated values select the next q_o as follows. J=0,K=0 holds q_o. J=1,K=0 gives 1. J=0,K=1 gives 0. J=1,K=1 inverts q_o.
- R5: pre_ni low with clr_ni high forces q_o=1 and qn_o=0 at once, independent of the clock. clr_ni low with pre_ni high forces q_o=0 and qn_o=1. The forced value remains after release.
- R6: pre_ni and clr_ni both low drive q_o=1 and qn_o=1. After release the outputs follow the control released last. If both release together, the outputs follow the stored slave value. Outside this state qn_o is the complement of q_o.
- R7: While preset or clear is active, a falling device-clock edge does not overwrite the forced slave value.
- R8: hold_viol_o becomes 1 and stays 1 when a gated J or K value changes during a device-clock high phase, after the phase's first cycle.
- R9: width_viol_o becomes 1 and stays 1 when a synchronized phase ends after fewer than MIN_PULSE_CYC cycles. The phases are device clock high, device clock low, preset low and clear low. A phase of exactly MIN_PULSE_CYC cycles does not set it.
- R10: A one-cycle flag_clr_i pulse clears both flags and leaves q_o unchanged.
- R11: After reset q_o=0, qn_o=1, hold_viol_o=0 and width_viol_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dclk_i | input | 1 | Device clock, sampled |
| j_i | input | 3 | J lines, ANDed |
| k_i | input | 3 | K lines, ANDed |
| pre_ni | input | 1 | Active-low preset |
| clr_ni | input | 1 | Active-low clear |
| flag_clr_i | input | 1 | Clears both violation flags |
| q_o | output | 1 | True output |
| qn_o | output | 1 | Complementary output |
| hold_viol_o | output | 1 | Sticky flag: J/K changed while the clock was high |
| width_viol_o | output | 1 | Sticky flag: a phase was too short |

## Verification
A table of full clock pulses walks every row of the J/K function from a known state. It includes partial AND patterns, which must behave as zero and so separate a true three-input AND from an OR or a single-line tap. The output is sampled in the middle of each high phase to separate falling-edge transfer from rising-edge transfer.

Directed sequences cover the override cases:
- Preset alone, clear alone and both together.
- The three release orders of preset and clear.
- A pulse that arrives while clear is held.

Further directed sequences cover the flags:
- A J/K change inside a high phase, which must be both ignored and flagged.
- High phases of MIN_PULSE_CYC and MIN_PULSE_CYC-1 cycles, which mark the exact width boundary.
- Short low, preset and clear phases.

// File: rtl/jk_pkg.sv
package jk_pkg;
  typedef enum int {
    PH_CLK_HI = 0,
    PH_CLK_LO = 1,
    PH_PRE_LO = 2,
    PH_CLR_LO = 3
  } phase_e;

  localparam int NUM_PHASES = 4;

  function automatic logic jk_next(input logic q, input logic j, input logic k);
    case ({j, k})
      2'b10:   return 1'b1;
      2'b01:   return 1'b0;
      2'b11:   return ~q;
      default: return q;
    endcase
  endfunction
endpackage

// File: rtl/jk_sync.sv
module jk_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign d_o = stg[STAGES-1];
endmodule

// File: rtl/jk_edge.sv
module jk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d <= 1'b0;
    else         lvl_d <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_d;
  assign fall_o = ~lvl_i & lvl_d;
endmodule

// File: rtl/jk_ms_core.sv
module jk_ms_core
  import jk_pkg::*;
#(
  parameter int N_IN = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dclk_s_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            pre_s_ni,
  input  logic            clr_s_ni,
  input  logic [N_IN-1:0] j_s_i,
  input  logic [N_IN-1:0] k_s_i,
  output logic            slave_o,
  output logic            hold_evt_o
);
  logic gj, gk, gj_d, gk_d;
  logic master_q, slave_q;

  assign gj = &j_s_i;
  assign gk = &k_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gj_d     <= 1'b0;
      gk_d     <= 1'b0;
      master_q <= 1'b0;
      slave_q  <= 1'b0;
    end else begin
      gj_d <= gj;
      gk_d <= gk;
      // master loads even while an override is active
      if (rise_i) master_q <= jk_next(slave_q, gj, gk);
      if (!pre_s_ni && clr_s_ni)      slave_q <= 1'b1;
      else if (pre_s_ni && !clr_s_ni) slave_q <= 1'b0;
      else if (pre_s_ni && clr_s_ni && fall_i) slave_q <= master_q;
    end
  end

  assign slave_o    = slave_q;
  // first high cycle (rise) may carry setup-time changes
  assign hold_evt_o = dclk_s_i & ~rise_i & ((gj ^ gj_d) | (gk ^ gk_d));
endmodule

// File: rtl/jk_width_mon.sv
module jk_width_mon #(
  parameter int MIN_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic short_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

  logic [CW-1:0] cnt;
  logic          act_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= LIMIT;
      act_d <= 1'b1;
    end else begin
      act_d <= act_i;
      if (act_i && !act_d)         cnt <= CW'(1);
      else if (act_i && cnt < LIMIT) cnt <= cnt + CW'(1);
    end
  end

  assign short_o = ~act_i & act_d & (cnt < LIMIT);
endmodule

// File: rtl/jk_ms_ff.sv
module jk_ms_ff
  import jk_pkg::*;
#(
  parameter int N_IN          = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_PULSE_CYC = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dclk_i,
  input  logic [N_IN-1:0] j_i,
  input  logic [N_IN-1:0] k_i,
  input  logic            pre_ni,
  input  logic            clr_ni,
  input  logic            flag_clr_i,
  output logic            q_o,
  output logic            qn_o,
  output logic            hold_viol_o,
  output logic            width_viol_o
);
  localparam int SW = 2 * N_IN + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, {(2*N_IN){1'b0}}, 2'b11};

  logic [SW-1:0]         sync_q;
  logic                  s_dclk, s_pre_n, s_clr_n;
  logic [N_IN-1:0]       s_j, s_k;
  logic                  dclk_rise, dclk_fall;
  logic                  slave_q, hold_evt;
  logic [NUM_PHASES-1:0] ph_act, ph_short;
  logic                  hold_viol_q, width_viol_q;

  jk_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({dclk_i, j_i, k_i, pre_ni, clr_ni}),
    .d_o (sync_q)
  );

  assign {s_dclk, s_j, s_k, s_pre_n, s_clr_n} = sync_q;

  jk_edge u_edge (
    .clk_i, .rst_ni,
    .lvl_i  (s_dclk),
    .rise_o (dclk_rise),
    .fall_o (dclk_fall)
  );

  jk_ms_core #(.N_IN(N_IN)) u_core (
    .clk_i, .rst_ni,
    .dclk_s_i   (s_dclk),
    .rise_i     (dclk_rise),
    .fall_i     (dclk_fall),
    .pre_s_ni   (s_pre_n),
    .clr_s_ni   (s_clr_n),
    .j_s_i      (s_j),
    .k_s_i      (s_k),
    .slave_o    (slave_q),
    .hold_evt_o (hold_evt)
  );

  assign ph_act[PH_CLK_HI] = s_dclk;
  assign ph_act[PH_CLK_LO] = ~s_dclk;
  assign ph_act[PH_PRE_LO] = ~s_pre_n;
  assign ph_act[PH_CLR_LO] = ~s_clr_n;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_wmon
    jk_width_mon #(.MIN_CYC(MIN_PULSE_CYC)) u_wmon (
      .clk_i, .rst_ni,
      .act_i   (ph_act[g]),
      .short_o (ph_short[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_viol_q  <= 1'b0;
      width_viol_q <= 1'b0;
    end else if (flag_clr_i) begin
      hold_viol_q  <= 1'b0;
      width_viol_q <= 1'b0;
    end else begin
      hold_viol_q  <= hold_viol_q | hold_evt;
      width_viol_q <= width_viol_q | (|ph_short);
    end
  end

  // raw controls override the outputs asynchronously
  assign q_o          = ~pre_ni | (clr_ni & slave_q);
  assign qn_o         = ~clr_ni | (pre_ni & ~slave_q);
  assign hold_viol_o  = hold_viol_q;
  assign width_viol_o = width_viol_q;
endmodule

// File: rtl/jk_ms_ff_chk.sv
module jk_ms_ff_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pre_ni,
  input logic clr_ni,
  input logic flag_clr_i,
  input logic q_o,
  input logic qn_o,
  input logic hold_viol_o,
  input logic width_viol_o,
  input logic dclk_fall,
  input logic s_pre_n,
  input logic s_clr_n
);
  // R5
  preset_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_ni && clr_ni) |-> (q_o && !qn_o));

  // R5
  clear_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_ni && !clr_ni) |-> (!q_o && qn_o));

  // R6
  both_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_ni && !clr_ni) |-> (q_o && qn_o));

  // R6
  complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_ni || clr_ni) |-> (q_o != qn_o));

  // R3
  fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_ni && clr_ni && $past(pre_ni && clr_ni) && $past(s_pre_n && s_clr_n)
     && !$past(dclk_fall)) |-> $stable(q_o));

  // R8
  hold_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold_viol_o) && !$past(flag_clr_i)) |-> hold_viol_o);

  // R9
  width_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(width_viol_o) && !$past(flag_clr_i)) |-> width_viol_o);

  // R10
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flag_clr_i) |-> (!hold_viol_o && !width_viol_o));
endmodule

bind jk_ms_ff jk_ms_ff_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pre_ni       (pre_ni),
  .clr_ni       (clr_ni),
  .flag_clr_i   (flag_clr_i),
  .q_o          (q_o),
  .qn_o         (qn_o),
  .hold_viol_o  (hold_viol_o),
  .width_viol_o (width_viol_o),
  .dclk_fall    (dclk_fall),
  .s_pre_n      (s_pre_n),
  .s_clr_n      (s_clr_n)
);

// File: tb/sim_jk_ms_ff.sv
module sim_jk_ms_ff;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_CYC    = 10;
  localparam int NVEC       = 9;
  // {j[2:0], k[2:0], expected q}
  localparam logic [6:0] VEC [NVEC] = '{
    {3'b111, 3'b000, 1'b1},
    {3'b000, 3'b000, 1'b1},
    {3'b111, 3'b111, 1'b0},
    {3'b111, 3'b111, 1'b1},
    {3'b011, 3'b000, 1'b1},
    {3'b000, 3'b111, 1'b0},
    {3'b111, 3'b110, 1'b1},
    {3'b101, 3'b101, 1'b1},
    {3'b000, 3'b111, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic dclk = 1'b0, pre_n = 1'b1, clr_n = 1'b1, fclr = 1'b0;
  logic [2:0] j = '0, k = '0;
  logic q, qn, hviol, wviol;
  logic mid_q;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jk_ms_ff #(.MIN_PULSE_CYC(MIN_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dclk_i(dclk), .j_i(j), .k_i(k),
    .pre_ni(pre_n), .clr_ni(clr_n), .flag_clr_i(fclr),
    .q_o(q), .qn_o(qn), .hold_viol_o(hviol), .width_viol_o(wviol)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] jv, input logic [2:0] kv, input int hi);
    @(negedge clk);
    j = jv; k = kv;
    wait_n(4);
    dclk = 1'b1;
    wait_n(hi / 2);
    mid_q = q;
    wait_n(hi - hi / 2);
    dclk = 1'b0;
    wait_n(8);
  endtask

  task automatic pulse_flags();
    @(negedge clk); fclr = 1'b1;
    @(negedge clk); fclr = 1'b0;
    wait_n(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    chk("R11", "q in reset", q, 1'b0);
    rst_n = 1'b1;
    wait_n(4);
    chk("R11", "q after reset", q, 1'b0);
    chk("R11", "qn after reset", qn, 1'b1);
    chk("R11", "hold flag after reset", hviol, 1'b0);
    chk("R11", "width flag after reset", wviol, 1'b0);

    // R1 R3 R4: function table walk
    for (int i = 0; i < NVEC; i++) begin
      logic prev;
      prev = q;
      pulse(VEC[i][6:4], VEC[i][3:1], 12);
      chk("R3", $sformatf("vec %0d q unchanged mid-pulse", i), mid_q, prev);
      chk("R4", $sformatf("vec %0d q (R1 gating)", i), q, VEC[i][0]);
      chk("R4", $sformatf("vec %0d qn", i), qn, ~VEC[i][0]);
    end
    chk("R8", "no hold flag after clean pulses", hviol, 1'b0);
    chk("R9", "no width flag after clean pulses", wviol, 1'b0);

    // R5 preset
    @(negedge clk); pre_n = 1'b0; #1;
    chk("R5", "preset q immediate", q, 1'b1);
    chk("R5", "preset qn immediate", qn, 1'b0);
    wait_n(14); pre_n = 1'b1; wait_n(5);
    chk("R5", "q retained after preset", q, 1'b1);
    // R5 clear
    @(negedge clk); clr_n = 1'b0; #1;
    chk("R5", "clear q immediate", q, 1'b0);
    chk("R5", "clear qn immediate", qn, 1'b1);
    wait_n(14); clr_n = 1'b1; wait_n(5);
    chk("R5", "q retained after clear", q, 1'b0);

    // R6 both low, clear released first
    @(negedge clk); pre_n = 1'b0; wait_n(14);
    clr_n = 1'b0; #1;
    chk("R6", "both low q", q, 1'b1);
    chk("R6", "both low qn", qn, 1'b1);
    wait_n(14); clr_n = 1'b1; wait_n(14); pre_n = 1'b1; wait_n(5);
    chk("R6", "preset released last q", q, 1'b1);
    // R6 preset released first
    @(negedge clk); pre_n = 1'b0; clr_n = 1'b0; wait_n(14);
    pre_n = 1'b1; wait_n(14); clr_n = 1'b1; wait_n(5);
    chk("R6", "clear released last q", q, 1'b0);
    chk("R6", "clear released last qn", qn, 1'b1);
    // R6 simultaneous release keeps slave
    @(negedge clk); pre_n = 1'b0; wait_n(14);
    clr_n = 1'b0; wait_n(14);
    pre_n = 1'b1; clr_n = 1'b1; wait_n(5);
    chk("R6", "simultaneous release q", q, 1'b1);

    // R7 pulse during clear
    @(negedge clk); clr_n = 1'b0; wait_n(14);
    pulse(3'b111, 3'b000, 12);
    chk("R7", "q forced during pulse", q, 1'b0);
    clr_n = 1'b1; wait_n(5);
    chk("R7", "slave not overwritten", q, 1'b0);

    // R2 R8 change during high
    @(negedge clk); j = 3'b111; k = 3'b000; wait_n(4);
    dclk = 1'b1; wait_n(5);
    j = 3'b000; k = 3'b111; wait_n(6);
    dclk = 1'b0; wait_n(8);
    chk("R2", "late change ignored", q, 1'b1);
    chk("R8", "hold flag set", hviol, 1'b1);
    chk("R8", "width flag untouched", wviol, 1'b0);
    wait_n(5);
    chk("R8", "hold flag sticky", hviol, 1'b1);
    pulse_flags();
    chk("R10", "hold flag cleared", hviol, 1'b0);
    chk("R10", "q unchanged by clear", q, 1'b1);

    // R9 width boundary
    pulse(3'b000, 3'b000, MIN_CYC);
    chk("R9", "high of MIN cycles no flag", wviol, 1'b0);
    pulse(3'b000, 3'b000, MIN_CYC - 1);
    chk("R9", "high of MIN-1 cycles flagged", wviol, 1'b1);
    pulse_flags();
    chk("R10", "width flag cleared", wviol, 1'b0);
    chk("R10", "q unchanged after width clear", q, 1'b1);
    @(negedge clk); pre_n = 1'b0; wait_n(3); pre_n = 1'b1; wait_n(6);
    chk("R9", "short preset flagged", wviol, 1'b1);
    pulse_flags();
    @(negedge clk); clr_n = 1'b0; wait_n(3); clr_n = 1'b1; wait_n(6);
    chk("R9", "short clear flagged", wviol, 1'b1);
    pulse_flags();
    chk("R9", "flag clear before low test", wviol, 1'b0);
    @(negedge clk); j = '0; k = '0; dclk = 1'b1; wait_n(12);
    dclk = 1'b0; wait_n(3); dclk = 1'b1; wait_n(12);
    dclk = 1'b0; wait_n(8);
    chk("R9", "short low phase flagged", wviol, 1'b1);
    chk("R8", "no hold flag with steady J/K", hviol, 1'b0);

    finish_run();
  end
endmodule